// File: doc/BRIEF.md
# Coprocessor Issue Gate

This block stands between a CPU's instruction stream and an external numeric coprocessor. It decides what happens to each instruction offered to it. A coprocessor-class (escape) instruction is either sent on to the coprocessor or turned into a trap. A WAIT instruction either completes, stalls while the coprocessor is busy, or is turned into a trap. Traps carry vector 7 (coprocessor not available) or vector 16 (coprocessor error).

The gate keeps its own four control bits:
- emulate: coprocessor instructions are handled by software.
- monitor: a coprocessor is attached.
- task-switched: the coprocessor context may be stale.
- type: selects the 32-bit handshake when set and the 16-bit handshake when clear.

These bits are changed by a control write, a task-switch pulse and a clear-task-switched pulse. Writes and clears take effect only at privilege level zero; other attempts are refused and reported. The coprocessor pins are active low: busy_n_i low means busy, and err_n_i low means an error is pending.

All outputs are registered. The gate answers in the cycle after an instruction is offered, and it holds the WAIT stall in its own state register.

Top module: `cop_issue_gate`

## Requirements
- R1: An instruction with is_wait_i clear is escape-class only when opcode_i[7:3] equals 5'b11011. Any other non-WAIT instruction raises no dispatch, no trap and no WAIT completion.
- R2: An escape with the emulate bit set raises a trap with vector 7 and is not dispatched. This check wins over every other check.
- R3: An escape with emulate clear and task-switched set raises a trap with vector 7.
- R4: An escape with emulate and task-switched clear, err_chk_i set and err_n_i low raises a trap with vector 16. An escape that passes all checks pulses dispatch_o, with disp_opc_o equal to its opcode.
- R5: A WAIT tests task-switched only when monitor is set. Monitor and task-switched both set give a trap with vector 7; task-switched alone has no effect.
- R6: A WAIT offered while busy_n_i is low raises stall_o from the next cycle. stall_o stays high until the cycle after busy_n_i is seen high. At that edge err_n_i is sampled: low gives a trap with vector 16, high gives a wait_done_o pulse.
- R7: A task-switch pulse sets task-switched. A clear pulse at privilege level zero clears it. If both arrive in the same cycle, the task switch wins.
- R8: During reset, emulate, monitor and task-switched are cleared. The type bit takes 1 if err_n_i is low and 0 if it is high.
- R9: A control write at privilege level zero loads type, task-switched, emulate and monitor from cr_wdata_i bits 3, 2, 1 and 0.
- R10: A control write or clear pulse with cpl0_i low changes no control bit and raises prot_viol_o for exactly one cycle.
- R11: A trap is a one-cycle pulse on exc_valid_o with a 5-bit vector on exc_vec_o, which is zero when no trap is raised. An instruction offered while a trap is being signalled, or while stall_o is high, is dropped.
- R12: Every output responds at the clock edge that samples its cause and is visible in the following cycle. The checks use the control bits as they were before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| insn_valid_i | input | 1 | An instruction is offered this cycle |
| opcode_i | input | 8 | First opcode byte |
| is_wait_i | input | 1 | The offered instruction is WAIT (opcode is then ignored) |
| err_chk_i | input | 1 | The escape must test the error pin |
| busy_n_i | input | 1 | Coprocessor busy, active low |
| err_n_i | input | 1 | Coprocessor error, active low |
| task_sw_i | input | 1 | Task-switch pulse |
| clr_ts_i | input | 1 | Clear task-switched pulse |
| cpl0_i | input | 1 | Requester is at privilege level zero |
| cr_wr_i | input | 1 | Control write strobe |
| cr_wdata_i | input | 4 | Control write data {type, task-switched, emulate, monitor} |
| dispatch_o | output | 1 | Escape sent on to the coprocessor |
| disp_opc_o | output | 8 | Opcode of the dispatched escape, zero otherwise |
| wait_done_o | output | 1 | WAIT finished without a trap |
| stall_o | output | 1 | WAIT is holding for the coprocessor |
| exc_valid_o | output | 1 | Trap request pulse |
| exc_vec_o | output | 5 | Trap vector (7 or 16) |
| prot_viol_o | output | 1 | Refused control write or clear |
| em_o | output | 1 | Emulate bit |
| mp_o | output | 1 | Monitor bit |
| ts_o | output | 1 | Task-switched bit |
| et_o | output | 1 | Coprocessor type bit |

## Verification
The bench targets several corner cases, each of which a faulty design would show at the ports:
- An escape with both emulate and task-switched set: a design that got the check order wrong could dispatch it or report an error trap.
- A WAIT with only task-switched set: a design that ignored the monitor qualifier would trap it with vector 7.
- A WAIT whose BUSY drops while an error is pending: a design that sampled ERROR before BUSY went inactive, or kept stalling afterwards, would give the wrong vector or stall one cycle too long.
- Back-to-back offers right after a trap, and a task switch together with a clear: instructions that should be dropped would be executed, or the task-switched bit would end in the wrong state.
- A reset under each level of the error pin, and refused writes from a non-zero privilege level: these catch a mis-sampled type bit and control bits that a refused write still corrupts.

// File: rtl/cig_pkg.sv
package cig_pkg;

    parameter int unsigned OPC_W = 8;
    parameter int unsigned VEC_W = 5;

    // Control bits; packed order gives write-data bit 3..0 = type, ts, em, mp
    typedef struct packed {
        logic et;
        logic ts;
        logic em;
        logic mp;
    } cr_bits_t;

    localparam int unsigned CR_W = $bits(cr_bits_t);

    // State of the control-bit register file
    typedef struct packed {
        cr_bits_t cr;
        logic     pv;
    } cr_state_t;

    // Combinational decision for one cycle
    typedef struct packed {
        logic             disp;
        logic             wdone;
        logic             exc;
        logic [VEC_W-1:0] vec;
        logic             hold;
    } verdict_t;

    // Registered gate outputs plus the WAIT hold flag
    typedef struct packed {
        logic             waiting;
        logic             disp;
        logic [OPC_W-1:0] opc;
        logic             wdone;
        logic             exc;
        logic [VEC_W-1:0] vec;
    } gate_st_t;

endpackage

// File: rtl/cig_cr_file.sv
module cig_cr_file
    import cig_pkg::*;
(
    input  logic     clk,
    input  logic     rst_i,
    input  logic     err_n_i,
    input  logic     wr_i,
    input  logic     cpl0_i,
    input  cr_bits_t wdata_i,
    input  logic     task_sw_i,
    input  logic     clr_ts_i,
    output cr_bits_t cr_o,
    output logic     pv_o
);

    cr_state_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.pv = (wr_i || clr_ts_i) && !cpl0_i;
        if (wr_i && cpl0_i) begin
            st_d.cr = wdata_i;
        end
        if (clr_ts_i && cpl0_i) begin
            st_d.cr.ts = 1'b0;
        end
        // task switch is applied last so it wins over a clear
        if (task_sw_i) begin
            st_d.cr.ts = 1'b1;
        end
        if (rst_i) begin
            st_d       = '0;
            st_d.cr.et = !err_n_i;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign cr_o = st_q.cr;
    assign pv_o = st_q.pv;

    // R7
    ts_set_chk: assert property (@(posedge clk) disable iff (rst_i)
        task_sw_i |=> cr_o.ts);

    // R10
    refused_wr_chk: assert property (@(posedge clk) disable iff (rst_i)
        ((wr_i || clr_ts_i) && !cpl0_i) |=>
            (pv_o && $stable(cr_o.em) && $stable(cr_o.mp) && $stable(cr_o.et)));

    // R10
    pv_pulse_chk: assert property (@(posedge clk) disable iff (rst_i)
        (pv_o && !$past(wr_i || clr_ts_i)) |-> 1'b0);

    // R9
    wr_load_chk: assert property (@(posedge clk) disable iff (rst_i)
        (wr_i && cpl0_i) |=> (cr_o.em == $past(wdata_i.em) && cr_o.mp == $past(wdata_i.mp)
                              && cr_o.et == $past(wdata_i.et)));

endmodule

// File: rtl/cig_classify.sv
module cig_classify
    import cig_pkg::*;
#(
    parameter int unsigned          ESC_W   = 5,
    parameter logic [ESC_W-1:0]     ESC_PAT = 5'b11011,
    parameter int unsigned          NM_VEC  = 7,
    parameter int unsigned          ERR_VEC = 16
) (
    input  logic             accept_i,
    input  logic             waiting_i,
    input  logic             valid_i,
    input  logic             is_wait_i,
    input  logic [ESC_W-1:0] prefix_i,
    input  logic             err_chk_i,
    input  logic             busy_n_i,
    input  logic             err_n_i,
    input  cr_bits_t         cr_i,
    output verdict_t         verdict_o
);

    localparam logic [VEC_W-1:0] NM_V  = NM_VEC[VEC_W-1:0];
    localparam logic [VEC_W-1:0] ERR_V = ERR_VEC[VEC_W-1:0];

    logic take;
    logic is_esc;

    assign take   = accept_i && valid_i;
    assign is_esc = !is_wait_i && (prefix_i == ESC_PAT);

    always_comb begin
        verdict_o = '0;
        if (waiting_i) begin
            // held WAIT: sample error only once busy has dropped
            verdict_o.hold = !busy_n_i;
            if (busy_n_i) begin
                if (!err_n_i) begin
                    verdict_o.exc = 1'b1;
                    verdict_o.vec = ERR_V;
                end else begin
                    verdict_o.wdone = 1'b1;
                end
            end
        end else if (take && is_wait_i) begin
            if (cr_i.mp && cr_i.ts) begin
                verdict_o.exc = 1'b1;
                verdict_o.vec = NM_V;
            end else if (!busy_n_i) begin
                verdict_o.hold = 1'b1;
            end else if (!err_n_i) begin
                verdict_o.exc = 1'b1;
                verdict_o.vec = ERR_V;
            end else begin
                verdict_o.wdone = 1'b1;
            end
        end else if (take && is_esc) begin
            if (cr_i.em || cr_i.ts) begin
                verdict_o.exc = 1'b1;
                verdict_o.vec = NM_V;
            end else if (err_chk_i && !err_n_i) begin
                verdict_o.exc = 1'b1;
                verdict_o.vec = ERR_V;
            end else begin
                verdict_o.disp = 1'b1;
            end
        end
    end

    // R11
    one_outcome_chk: assert final ($countones({verdict_o.disp, verdict_o.wdone,
                                                verdict_o.exc, verdict_o.hold}) <= 1);

endmodule

// File: rtl/cop_issue_gate.sv
module cop_issue_gate
    import cig_pkg::*;
#(
    parameter int unsigned          ESC_W   = 5,
    parameter logic [ESC_W-1:0]     ESC_PAT = 5'b11011,
    parameter int unsigned          NM_VEC  = 7,
    parameter int unsigned          ERR_VEC = 16
) (
    input  logic             clk,
    input  logic             rst_i,
    input  logic             insn_valid_i,
    input  logic [OPC_W-1:0] opcode_i,
    input  logic             is_wait_i,
    input  logic             err_chk_i,
    input  logic             busy_n_i,
    input  logic             err_n_i,
    input  logic             task_sw_i,
    input  logic             clr_ts_i,
    input  logic             cpl0_i,
    input  logic             cr_wr_i,
    input  logic [CR_W-1:0]  cr_wdata_i,
    output logic             dispatch_o,
    output logic [OPC_W-1:0] disp_opc_o,
    output logic             wait_done_o,
    output logic             stall_o,
    output logic             exc_valid_o,
    output logic [VEC_W-1:0] exc_vec_o,
    output logic             prot_viol_o,
    output logic             em_o,
    output logic             mp_o,
    output logic             ts_o,
    output logic             et_o
);

    gate_st_t st_d, st_q;
    cr_bits_t cr;
    verdict_t verdict;
    logic     accept;

    // no new instruction while a trap is signalled or a WAIT is held
    assign accept = !st_q.waiting && !st_q.exc;

    cig_cr_file u_cr (
        .clk       (clk),
        .rst_i     (rst_i),
        .err_n_i   (err_n_i),
        .wr_i      (cr_wr_i),
        .cpl0_i    (cpl0_i),
        .wdata_i   (cr_bits_t'(cr_wdata_i)),
        .task_sw_i (task_sw_i),
        .clr_ts_i  (clr_ts_i),
        .cr_o      (cr),
        .pv_o      (prot_viol_o)
    );

    cig_classify #(
        .ESC_W   (ESC_W),
        .ESC_PAT (ESC_PAT),
        .NM_VEC  (NM_VEC),
        .ERR_VEC (ERR_VEC)
    ) u_cls (
        .accept_i  (accept),
        .waiting_i (st_q.waiting),
        .valid_i   (insn_valid_i),
        .is_wait_i (is_wait_i),
        .prefix_i  (opcode_i[OPC_W-1 -: ESC_W]),
        .err_chk_i (err_chk_i),
        .busy_n_i  (busy_n_i),
        .err_n_i   (err_n_i),
        .cr_i      (cr),
        .verdict_o (verdict)
    );

    always_comb begin
        st_d         = '0;
        st_d.waiting = verdict.hold;
        st_d.disp    = verdict.disp;
        st_d.opc     = verdict.disp ? opcode_i : '0;
        st_d.wdone   = verdict.wdone;
        st_d.exc     = verdict.exc;
        st_d.vec     = verdict.vec;
        if (rst_i) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign dispatch_o  = st_q.disp;
    assign disp_opc_o  = st_q.opc;
    assign wait_done_o = st_q.wdone;
    assign stall_o     = st_q.waiting;
    assign exc_valid_o = st_q.exc;
    assign exc_vec_o   = st_q.vec;
    assign em_o        = cr.em;
    assign mp_o        = cr.mp;
    assign ts_o        = cr.ts;
    assign et_o        = cr.et;

    // R11
    exc_pulse_chk: assert property (@(posedge clk) disable iff (rst_i)
        exc_valid_o |=> !exc_valid_o);

    // R11
    exc_vec_chk: assert property (@(posedge clk) disable iff (rst_i)
        exc_valid_o |-> (exc_vec_o == NM_VEC[VEC_W-1:0] || exc_vec_o == ERR_VEC[VEC_W-1:0]));

    // R2
    no_disp_on_trap_chk: assert property (@(posedge clk) disable iff (rst_i)
        !(exc_valid_o && (dispatch_o || wait_done_o)));

    // R6
    stall_exit_chk: assert property (@(posedge clk) disable iff (rst_i)
        $fell(stall_o) |-> (wait_done_o || exc_valid_o));

    // R6
    stall_busy_chk: assert property (@(posedge clk) disable iff (rst_i)
        (stall_o && !busy_n_i) |=> stall_o);

    // R2
    em_trap_chk: assert property (@(posedge clk) disable iff (rst_i)
        (accept && insn_valid_i && !is_wait_i && opcode_i[OPC_W-1 -: ESC_W] == ESC_PAT && em_o)
            |=> (exc_valid_o && exc_vec_o == NM_VEC[VEC_W-1:0]));

endmodule

// File: tb/cop_issue_gate_tb.sv
`timescale 1ns/1ps
module cop_issue_gate_tb;

    logic       clk = 1'b0;
    logic       rst_i;
    logic       insn_valid_i;
    logic [7:0] opcode_i;
    logic       is_wait_i, err_chk_i, busy_n_i, err_n_i;
    logic       task_sw_i, clr_ts_i, cpl0_i, cr_wr_i;
    logic [3:0] cr_wdata_i;
    logic       dispatch_o, wait_done_o, stall_o, exc_valid_o, prot_viol_o;
    logic [7:0] disp_opc_o;
    logic [4:0] exc_vec_o;
    logic       em_o, mp_o, ts_o, et_o;

    int n_tests = 0;
    int n_fail  = 0;

    // model state
    logic m_em, m_mp, m_ts, m_et, m_wait, m_exc;
    // expected outputs
    logic       e_disp, e_wdone, e_exc, e_stall, e_pv;
    logic [7:0] e_opc;
    logic [4:0] e_vec;

    always #2 clk = ~clk;

    cop_issue_gate u_dut (
        .clk(clk), .rst_i(rst_i), .insn_valid_i(insn_valid_i), .opcode_i(opcode_i),
        .is_wait_i(is_wait_i), .err_chk_i(err_chk_i), .busy_n_i(busy_n_i), .err_n_i(err_n_i),
        .task_sw_i(task_sw_i), .clr_ts_i(clr_ts_i), .cpl0_i(cpl0_i), .cr_wr_i(cr_wr_i),
        .cr_wdata_i(cr_wdata_i), .dispatch_o(dispatch_o), .disp_opc_o(disp_opc_o),
        .wait_done_o(wait_done_o), .stall_o(stall_o), .exc_valid_o(exc_valid_o),
        .exc_vec_o(exc_vec_o), .prot_viol_o(prot_viol_o), .em_o(em_o), .mp_o(mp_o),
        .ts_o(ts_o), .et_o(et_o)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
        end
    endtask

    function automatic logic is_esc(input logic [7:0] op);
        return op[7:3] == 5'b11011;
    endfunction

    task automatic idle_inputs();
        insn_valid_i = 0; opcode_i = 8'h00; is_wait_i = 0; err_chk_i = 0;
        busy_n_i = 1; err_n_i = 1; task_sw_i = 0; clr_ts_i = 0; cpl0_i = 1;
        cr_wr_i = 0; cr_wdata_i = 4'h0;
    endtask

    // compute expectation from the model and current inputs, advance one cycle, compare
    task automatic cyc();
        logic acc, nw;
        acc = !m_wait && !m_exc;
        e_disp = 0; e_wdone = 0; e_exc = 0; e_vec = 0; e_opc = 0; nw = 0;
        if (m_wait) begin
            if (!busy_n_i) nw = 1;
            else if (!err_n_i) begin e_exc = 1; e_vec = 16; end
            else e_wdone = 1;
        end else if (acc && insn_valid_i && is_wait_i) begin
            if (m_mp && m_ts) begin e_exc = 1; e_vec = 7; end
            else if (!busy_n_i) nw = 1;
            else if (!err_n_i) begin e_exc = 1; e_vec = 16; end
            else e_wdone = 1;
        end else if (acc && insn_valid_i && is_esc(opcode_i)) begin
            if (m_em || m_ts) begin e_exc = 1; e_vec = 7; end
            else if (err_chk_i && !err_n_i) begin e_exc = 1; e_vec = 16; end
            else begin e_disp = 1; e_opc = opcode_i; end
        end
        e_stall = nw;
        e_pv = (cr_wr_i || clr_ts_i) && !cpl0_i;
        if (cr_wr_i && cpl0_i) {m_et, m_ts, m_em, m_mp} = cr_wdata_i;
        if (clr_ts_i && cpl0_i) m_ts = 0;
        if (task_sw_i) m_ts = 1;
        m_wait = nw; m_exc = e_exc;
        @(negedge clk);
        chk("R4", "dispatch", dispatch_o, e_disp);
        chk("R4", "disp_opc", disp_opc_o, e_opc);
        chk("R6", "wait_done", wait_done_o, e_wdone);
        chk("R6", "stall", stall_o, e_stall);
        chk("R11", "exc_valid", exc_valid_o, e_exc);
        chk("R11", "exc_vec", exc_vec_o, e_vec);
        chk("R10", "prot_viol", prot_viol_o, e_pv);
        chk("R9", "cr bits", {et_o, ts_o, em_o, mp_o}, {m_et, m_ts, m_em, m_mp});
        idle_inputs();
    endtask

    task automatic do_reset(input logic err_lvl);
        idle_inputs();
        rst_i = 1; err_n_i = err_lvl;
        repeat (3) @(negedge clk);
        rst_i = 0; err_n_i = 1;
        m_em = 0; m_mp = 0; m_ts = 0; m_et = !err_lvl; m_wait = 0; m_exc = 0;
        // R8 reset state
        chk("R8", "reset cr bits", {et_o, ts_o, em_o, mp_o}, {!err_lvl, 3'b000});
        chk("R8", "reset outputs", {dispatch_o, wait_done_o, stall_o, exc_valid_o, prot_viol_o}, 0);
    endtask

    task automatic wr_cr(input logic [3:0] v);
        cr_wr_i = 1; cpl0_i = 1; cr_wdata_i = v; cyc();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_c0de));
        idle_inputs();
        rst_i = 1;
        do_reset(1'b0);           // R8: error pin low gives type = 1

        // R9 clear all bits at PL0
        wr_cr(4'b0000);
        // R4 checked escape with error pending -> 16; next offer dropped (R11)
        insn_valid_i = 1; opcode_i = 8'hD9; err_chk_i = 1; err_n_i = 0; cyc();
        insn_valid_i = 1; opcode_i = 8'hD9; cyc();
        // R4 unchecked escape ignores the error pin -> dispatch
        insn_valid_i = 1; opcode_i = 8'hDD; err_chk_i = 0; err_n_i = 0; cyc();
        // R1 non-escape opcodes do nothing
        insn_valid_i = 1; opcode_i = 8'h90; cyc();
        insn_valid_i = 1; opcode_i = 8'hE0; cyc();
        // R2 emulate and task-switched both set -> vector 7
        wr_cr(4'b0110);
        insn_valid_i = 1; opcode_i = 8'hD8; err_chk_i = 1; err_n_i = 0; cyc();
        cyc();
        // R3 task-switched only
        wr_cr(4'b0100);
        insn_valid_i = 1; opcode_i = 8'hDF; cyc();
        cyc();
        // R5 WAIT with task-switched alone completes
        insn_valid_i = 1; is_wait_i = 1; cyc();
        // R5 WAIT with monitor and task-switched -> 7
        wr_cr(4'b0101);
        insn_valid_i = 1; is_wait_i = 1; busy_n_i = 0; cyc();
        cyc();
        // R6 WAIT stalls on busy, then error -> 16
        wr_cr(4'b0001);
        insn_valid_i = 1; is_wait_i = 1; busy_n_i = 0; cyc();
        insn_valid_i = 1; opcode_i = 8'hD8; busy_n_i = 0; err_n_i = 0; cyc();
        busy_n_i = 0; cyc();
        busy_n_i = 1; err_n_i = 0; cyc();
        cyc();
        // R6 WAIT stalls then completes cleanly
        insn_valid_i = 1; is_wait_i = 1; busy_n_i = 0; cyc();
        busy_n_i = 1; cyc();
        // R10 refused write and clear
        cr_wr_i = 1; cpl0_i = 0; cr_wdata_i = 4'b1110; cyc();
        task_sw_i = 1; cyc();
        clr_ts_i = 1; cpl0_i = 0; cyc();
        // R7 clear at PL0, then clear together with task switch
        clr_ts_i = 1; cpl0_i = 1; cyc();
        clr_ts_i = 1; task_sw_i = 1; cpl0_i = 1; cyc();

        // constrained random (R12 timing on every cycle)
        for (int i = 0; i < 4000; i++) begin
            insn_valid_i = ($urandom % 10) < 6;
            is_wait_i    = ($urandom % 10) < 3;
            opcode_i     = ($urandom % 2) ? {5'b11011, 3'($urandom)} : 8'($urandom);
            err_chk_i    = $urandom % 2;
            busy_n_i     = ($urandom % 10) >= 3;
            err_n_i      = ($urandom % 4) != 0;
            task_sw_i    = ($urandom % 12) == 0;
            clr_ts_i     = ($urandom % 8) == 0;
            cr_wr_i      = ($urandom % 12) == 0;
            cpl0_i       = ($urandom % 4) != 0;
            cr_wdata_i   = 4'($urandom);
            if (cr_wdata_i[1] && ($urandom % 2)) cr_wdata_i[1] = 0;
            cyc();
        end

        do_reset(1'b1);           // R8: error pin high gives type = 0
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule